// File: doc/BRIEF.md
# Serial configuration and control-mode controller

This block is the control side of a data converter. After reset it sits in pin-strapped mode, where the output standard follows the level on the serial data pin and the output data format follows the level on the serial clock pin. The first falling edge of chip select moves it for good into serial register mode. At that moment it latches both strap levels into its output-data register.

From then on a host reaches a small register file over a three-wire serial bus with one bidirectional data line. The file holds the channel select, the operating mode with a self-clearing software reset, the clock options, the reference trim and the output data settings. Every setting is driven straight out to the rest of the chip.

All pins are brought into the system clock domain through two-flop synchronisers. The bus is then decoded from edges seen in that domain. The bidirectional pad is split into a separate input, an output and an output enable.

Top module: `cfg_ctrl_if`

## Requirements
- R1: After reset the block is in pin mode (`spi_mode`=0) with `sdio_oe`=0. The defaults are `ch_sel`=3, `op_mode`=0, `clk_se`=0, `clk_div2`=0, `dcs_en`=1, `ref_en`=0 and `ref_step`=0.
- R2: In pin mode, `out_lvds` equals the `sdio_in` level (1 = LVDS DDR, 0 = CMOS). `data_fmt` is 00 (offset binary) when `sclk` is low and 01 (two's complement) when `sclk` is high.
- R3: The first falling edge of `cs_n` sets `spi_mode` to 1 and keeps it there. At that edge `out_lvds` and the format are captured from the pins, and later pin levels and later `cs_n` falls do not change them.
- R4: Each frame is sampled on rising `sclk` while `cs_n` is low. It carries, MSB first: a direction bit (1 = read), a 2-bit length L, a 13-bit address, then L+1 data bytes MSB first. The address increments after each byte, and bits clocked after the last byte are ignored.
- R5: The register map is as follows. 0x0003 bits[1:0] = `ch_sel`. 0x0005 bits[1:0] = `op_mode`, and bit7 = software reset. 0x0006 bit2 = `clk_se`, bit1 = `clk_div2`, bit0 = `dcs_en`. 0x0008 bit3 = `ref_en`, bits[2:0] = full-scale step code. 0x0011 bit3 = output standard, bits[1:0] = format code. Unused bits read back as 0.
- R6: In a read frame, `sdio_oe` rises after the 16 header bits. `sdio_out` then presents each data bit, MSB first, before the rising `sclk` edge that would sample it. `sdio_oe` stays high until `cs_n` rises and falls within a few clocks after that. `sdio_oe` stays low throughout a write frame.
- R7: Format codes are 00 offset binary, 01 two's complement and 10 Gray code. Code 11 is stored and read back as written, but `data_fmt` shows 00 for it.
- R8: A write of step code 7 (reserved) to 0x0008 leaves `ref_step` unchanged, while `ref_en` still takes the written bit.
- R9: Writing 0x0005 with bit7 set restores every register to its R1 default and ignores the other bits of that byte. The output-data register returns to the strap values captured at entry. The reset bit reads back as 0, and `spi_mode` stays 1.
- R10: Writes to unmapped addresses change no output, and reads of unmapped addresses return 0x00.
- R11: Gray code (`data_fmt`=10) can appear only after a register write; it never appears in pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; format strap in pin mode |
| sdio_in | input | 1 | Serial data from the pad; standard strap in pin mode |
| sdio_out | output | 1 | Serial read data to the pad |
| sdio_oe | output | 1 | Pad output enable for read data |
| spi_mode | output | 1 | 1 once serial register mode is entered |
| ch_sel | output | 2 | Channel select |
| op_mode | output | 2 | Operating mode code |
| clk_se | output | 1 | Single-ended clock input select |
| clk_div2 | output | 1 | Clock divide-by-two enable |
| dcs_en | output | 1 | Duty-cycle stabiliser enable |
| ref_en | output | 1 | Internal reference trim enable |
| ref_step | output | 3 | Full-scale step code, 0 to 6 dB down |
| out_lvds | output | 1 | Output standard, 1 = LVDS DDR |
| data_fmt | output | 2 | Effective output data format |

## Verification
A pin change reaches the synchronised level two clocks later, and the decoded edge updates a register on the third clock. A written setting is therefore visible three clocks after the rising `sclk` that carries the last bit of its byte. A read bit appears on `sdio_out` four clocks after the rising edge that ends the previous bit, and `sdio_oe` drops within six clocks of `cs_n` rising. The bench holds each `sclk` phase for eight clocks, samples read data just before the next rising edge, and checks settings only after the frame has closed and ten further clocks have passed, so every result is sampled after it is due.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_ADDR_W = 13;
  localparam int CFG_LEN_W  = 2;
  localparam int CFG_BYTE_W = 8;

  localparam logic [CFG_ADDR_W-1:0] A_CHAN = 13'h0003;
  localparam logic [CFG_ADDR_W-1:0] A_MODE = 13'h0005;
  localparam logic [CFG_ADDR_W-1:0] A_CLK  = 13'h0006;
  localparam logic [CFG_ADDR_W-1:0] A_REF  = 13'h0008;
  localparam logic [CFG_ADDR_W-1:0] A_OUT  = 13'h0011;

  localparam logic [1:0] FMT_OFFSET = 2'b00;
  localparam logic [1:0] FMT_TWOS   = 2'b01;
  localparam logic [1:0] FMT_GRAY   = 2'b10;
  localparam logic [2:0] STEP_RSVD  = 3'd7;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_DATA, PH_DONE} phase_t;

  typedef struct packed {
    logic [1:0] ch_sel;
    logic [1:0] op_mode;
    logic       clk_se;
    logic       clk_div2;
    logic       dcs_en;
    logic       ref_en;
    logic [2:0] ref_step;
    logic       out_lvds;
    logic [1:0] fmt;
  } cfg_t;

  function automatic logic [1:0] fmt_effective(logic [1:0] code);
    return (code == 2'b11) ? FMT_OFFSET : code;
  endfunction

  function automatic logic [2:0] step_next(logic [2:0] cur, logic [2:0] req);
    return (req == STEP_RSVD) ? cur : req;
  endfunction

  function automatic cfg_t cfg_default(logic lvds, logic [1:0] fmt);
    cfg_t c;
    c          = '0;
    c.ch_sel   = 2'b11;
    c.dcs_en   = 1'b1;
    c.out_lvds = lvds;
    c.fmt      = fmt;
    return c;
  endfunction

  function automatic cfg_t cfg_write(cfg_t cur, logic [CFG_ADDR_W-1:0] a,
                                     logic [CFG_BYTE_W-1:0] d);
    cfg_t n;
    n = cur;
    case (a)
      A_CHAN: n.ch_sel = d[1:0];
      A_MODE: n.op_mode = d[1:0];
      A_CLK:  {n.clk_se, n.clk_div2, n.dcs_en} = d[2:0];
      A_REF: begin
        n.ref_en   = d[3];
        n.ref_step = step_next(cur.ref_step, d[2:0]);
      end
      A_OUT: begin
        n.out_lvds = d[3];
        n.fmt      = d[1:0];
      end
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic [CFG_BYTE_W-1:0] cfg_read(cfg_t c, logic [CFG_ADDR_W-1:0] a);
    case (a)
      A_CHAN:  return {6'b0, c.ch_sel};
      A_MODE:  return {6'b0, c.op_mode};
      A_CLK:   return {5'b0, c.clk_se, c.clk_div2, c.dcs_en};
      A_REF:   return {4'b0, c.ref_en, c.ref_step};
      A_OUT:   return {4'b0, c.out_lvds, 1'b0, c.fmt};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= pin_i[g];
        s2 <= s1;
      end
    end
    assign lvl_o[g] = s2;
  end
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int LEN_W  = CFG_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int HDR_BITS = 1 + LEN_W + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS);
  localparam logic [CNT_W-1:0] HCNT_LAST = CNT_W'(HDR_BITS - 1);

  phase_t              phase;
  logic [HDR_BITS-2:0] shreg;
  logic [HDR_BITS-1:0] hdr_full;
  logic [CNT_W-1:0]    hcnt;
  logic                rw_q;
  logic [LEN_W-1:0]    len_q, byte_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [2:0]          bit_q;
  logic [6:0]          wsh;
  logic                sdo_q, oe_q;
  logic                bit_evt;

  assign hdr_full = {shreg, sdi};
  assign bit_evt  = sclk_rise && !cs_rise && !cs_fall;
  assign wr_stb   = bit_evt && (phase == PH_DATA) && !rw_q && (bit_q == 3'd7);
  assign wr_data  = {wsh, sdi};
  assign bus_addr = addr_q;
  assign sdo      = sdo_q;
  assign sdo_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      shreg  <= '0;
      hcnt   <= '0;
      rw_q   <= 1'b0;
      len_q  <= '0;
      byte_q <= '0;
      addr_q <= '0;
      bit_q  <= '0;
      wsh    <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (cs_rise) begin
        phase <= PH_IDLE;
      end else if (cs_fall) begin
        phase <= PH_HDR;
        hcnt  <= '0;
        rw_q  <= 1'b0;
      end else if (sclk_rise) begin
        case (phase)
          PH_HDR: begin
            shreg <= hdr_full[HDR_BITS-2:0];
            hcnt  <= hcnt + CNT_W'(1);
            if (hcnt == HCNT_LAST) begin
              phase  <= PH_DATA;
              rw_q   <= hdr_full[HDR_BITS-1];
              len_q  <= hdr_full[ADDR_W +: LEN_W];
              addr_q <= hdr_full[ADDR_W-1:0];
              bit_q  <= '0;
              byte_q <= '0;
            end
          end
          PH_DATA: begin
            wsh   <= wr_data[6:0];
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              addr_q <= addr_q + ADDR_W'(1);
              byte_q <= byte_q + LEN_W'(1);
              if (byte_q == len_q) phase <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
      sdo_q <= (phase == PH_DATA) && rw_q && rd_data[3'd7 - bit_q];
      oe_q  <= rw_q && ((phase == PH_DATA) || (phase == PH_DONE));
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_enter,
  input  logic              strap_lvds,
  input  logic [1:0]        strap_fmt,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              srst_pulse,
  output cfg_t              cfg
);
  logic       strap_lvds_q;
  logic [1:0] strap_fmt_q;

  assign srst_pulse = wr_stb && (bus_addr == A_MODE) && wr_data[7];
  assign rd_data    = cfg_read(cfg, bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg          <= cfg_default(1'b0, FMT_OFFSET);
      strap_lvds_q <= 1'b0;
      strap_fmt_q  <= FMT_OFFSET;
    end else if (spi_enter) begin
      strap_lvds_q <= strap_lvds;
      strap_fmt_q  <= strap_fmt;
      cfg.out_lvds <= strap_lvds;
      cfg.fmt      <= strap_fmt;
    end else if (srst_pulse) begin
      cfg <= cfg_default(strap_lvds_q, strap_fmt_q);
    end else if (wr_stb) begin
      cfg <= cfg_write(cfg, bus_addr, wr_data);
    end
  end
endmodule

// File: rtl/cfg_ctrl_if.sv
module cfg_ctrl_if
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int LEN_W  = CFG_LEN_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdio_in,
  output logic       sdio_out,
  output logic       sdio_oe,
  output logic       spi_mode,
  output logic [1:0] ch_sel,
  output logic [1:0] op_mode,
  output logic       clk_se,
  output logic       clk_div2,
  output logic       dcs_en,
  output logic       ref_en,
  output logic [2:0] ref_step,
  output logic       out_lvds,
  output logic [1:0] data_fmt
);
  logic [2:0]        lvl;
  logic              cs_lvl, sclk_lvl, sdio_lvl;
  logic              cs_prev, sclk_prev;
  logic              cs_fall, cs_rise, sclk_rise;
  logic              spi_mode_q, spi_enter, cs_active;
  logic              wr_stb, srst_pulse;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        wr_data, rd_data;
  cfg_t              cfg;

  cfg_pin_sync #(.N(3), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({cs_n, sclk, sdio_in}), .lvl_o(lvl)
  );
  assign {cs_lvl, sclk_lvl, sdio_lvl} = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev    <= 1'b1;
      sclk_prev  <= 1'b0;
      spi_mode_q <= 1'b0;
    end else begin
      cs_prev   <= cs_lvl;
      sclk_prev <= sclk_lvl;
      if (cs_fall) spi_mode_q <= 1'b1;
    end
  end

  assign cs_fall   = cs_prev && !cs_lvl;
  assign cs_rise   = !cs_prev && cs_lvl;
  assign sclk_rise = !sclk_prev && sclk_lvl && !cs_lvl;
  assign spi_enter = cs_fall && !spi_mode_q;
  assign cs_active = !cs_lvl;

  cfg_spi_frame #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sdi(sdio_lvl), .rd_data(rd_data),
    .bus_addr(bus_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .sdo(sdio_out), .sdo_oe(sdio_oe)
  );

  cfg_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .spi_enter(spi_enter),
    .strap_lvds(sdio_lvl), .strap_fmt({1'b0, sclk_lvl}),
    .wr_stb(wr_stb), .bus_addr(bus_addr), .wr_data(wr_data),
    .rd_data(rd_data), .srst_pulse(srst_pulse), .cfg(cfg)
  );

  assign spi_mode = spi_mode_q;
  assign ch_sel   = cfg.ch_sel;
  assign op_mode  = cfg.op_mode;
  assign clk_se   = cfg.clk_se;
  assign clk_div2 = cfg.clk_div2;
  assign dcs_en   = cfg.dcs_en;
  assign ref_en   = cfg.ref_en;
  assign ref_step = cfg.ref_step;
  assign out_lvds = spi_mode_q ? cfg.out_lvds : sdio_lvl;
  assign data_fmt = spi_mode_q ? fmt_effective(cfg.fmt) : {1'b0, sclk_lvl};
endmodule

// File: rtl/cfg_ctrl_if_chk.sv
module cfg_ctrl_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_mode,
  input logic       cs_active,
  input logic       sdio_oe,
  input logic       wr_stb,
  input logic       srst_pulse,
  input logic [1:0] data_fmt,
  input logic [2:0] ref_step,
  input logic [1:0] op_mode,
  input logic [1:0] ch_sel,
  input logic       dcs_en
);
  AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode); // R3
  AST_NO_GRAY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mode |-> data_fmt != 2'b10); // R11
  AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    data_fmt != 2'b11); // R7
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step != 3'd7); // R8
  AST_WR_IN_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> spi_mode); // R4
  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdio_oe); // R6
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_active) |-> ##2 !sdio_oe); // R6
  AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> (op_mode == 2'b00 && ch_sel == 2'b11 && dcs_en)); // R9
endmodule

bind cfg_ctrl_if cfg_ctrl_if_chk i_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cs_active(cs_active),
  .sdio_oe(sdio_oe), .wr_stb(wr_stb), .srst_pulse(srst_pulse),
  .data_fmt(data_fmt), .ref_step(ref_step), .op_mode(op_mode),
  .ch_sel(ch_sel), .dcs_en(dcs_en)
);

// File: tb/test_cfg_ctrl_if.sv
module test_cfg_ctrl_if;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cs_n, sclk, sdio_in;
  logic       sdio_out, sdio_oe, spi_mode;
  logic [1:0] ch_sel, op_mode, data_fmt;
  logic       clk_se, clk_div2, dcs_en, ref_en, out_lvds;
  logic [2:0] ref_step;

  cfg_ctrl_if i_cfg_ctrl_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .spi_mode(spi_mode),
    .ch_sel(ch_sel), .op_mode(op_mode), .clk_se(clk_se), .clk_div2(clk_div2),
    .dcs_en(dcs_en), .ref_en(ref_en), .ref_step(ref_step),
    .out_lvds(out_lvds), .data_fmt(data_fmt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, in_write = 0, oe_bad = 0;

  logic [1:0] e_ch, e_op, e_fmt;
  logic       e_se, e_div, e_dcs, e_ren, e_lvds;
  logic [2:0] e_step;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [1:0] eff_fmt(logic [1:0] c);
    return c[1] & c[0] ? 2'b00 : c;
  endfunction

  function automatic logic [14:0] dut_vec();
    return {ch_sel, op_mode, clk_se, clk_div2, dcs_en, ref_en, ref_step, out_lvds, data_fmt};
  endfunction

  function automatic logic [14:0] exp_vec();
    return {e_ch, e_op, e_se, e_div, e_dcs, e_ren, e_step, e_lvds, eff_fmt(e_fmt)};
  endfunction

  task automatic put_bit(input logic b, output logic smp, output logic oe_s);
    sdio_in = b;
    wait_clk(8);
    smp  = sdio_out;
    oe_s = sdio_oe;
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic rd, input logic [1:0] w, input logic [12:0] a,
                      input int nb, input logic [31:0] wd,
                      output logic [31:0] rdv, output logic oe_all);
    logic [15:0] hdr;
    logic s, o;
    hdr = {rd, w, a};
    rdv = '0;
    oe_all = 1'b1;
    in_write = !rd;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 15; i >= 0; i--) put_bit(hdr[i], s, o);
    for (int k = 0; k < nb; k++)
      for (int j = 7; j >= 0; j--) begin
        put_bit(rd ? 1'b0 : wd[24 - 8*k + j], s, o);
        rdv[24 - 8*k + j] = s;
        oe_all &= o;
      end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(10);
    in_write = 0;
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [31:0] r;
    logic o;
    xfer(1'b0, 2'd0, a, 1, {d, 24'h0}, r, o);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    logic [31:0] r;
    logic o;
    xfer(1'b1, 2'd0, a, 1, 32'h0, r, o);
    d = r[31:24];
  endtask

  always @(negedge clk) if (in_write && sdio_oe) oe_bad = 1;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_test();
  end

  initial begin
    logic [7:0]  rb;
    logic [31:0] rv;
    logic        oe_ok;
    rst_n = 0; cs_n = 1; sclk = 0; sdio_in = 0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);

    e_ch = 2'b11; e_op = 0; e_se = 0; e_div = 0; e_dcs = 1; e_ren = 0; e_step = 0;
    e_lvds = 0; e_fmt = 0;
    chk("R1 reset vector", dut_vec(), exp_vec());
    chk("R1 reset spi_mode", spi_mode, 0);
    chk("R1 reset oe", sdio_oe, 0);

    for (int v = 0; v < 4; v++) begin
      sdio_in = v[1]; sclk = v[0];
      wait_clk(6);
      chk("R2 pin out_lvds", out_lvds, v[1]);
      chk("R2 pin data_fmt", data_fmt, {1'b0, v[0]});
      chk("R11 no gray in pin mode", data_fmt == 2'b10, 0);
      chk("R2 still pin mode", spi_mode, 0);
    end
    sclk = 0;

    sdio_in = 1; sclk = 0;
    wait_clk(6);
    cs_n = 0; wait_clk(10); cs_n = 1; wait_clk(10);
    e_lvds = 1; e_fmt = 0;
    chk("R3 spi_mode set", spi_mode, 1);
    chk("R3 strap captured", dut_vec(), exp_vec());
    sdio_in = 0; sclk = 1;
    wait_clk(10);
    chk("R3 pins ignored after entry", dut_vec(), exp_vec());
    sclk = 0;
    wait_clk(4);
    rd1(cfg_pkg::A_OUT, rb);
    chk("R3 strap readback", rb, 8'h08);

    for (int f = 0; f < 4; f++) begin
      wr1(cfg_pkg::A_OUT, {4'b0, f[0], 1'b0, f[1:0]});
      e_lvds = f[0]; e_fmt = f[1:0];
      chk("R7 format output", dut_vec(), exp_vec());
      rd1(cfg_pkg::A_OUT, rb);
      chk("R7 format readback", rb, {4'b0, f[0], 1'b0, f[1:0]});
    end
    chk("R11 gray only via write", data_fmt, 2'b00);

    for (int s = 0; s < 8; s++) begin
      wr1(cfg_pkg::A_REF, {4'b0, s[0], s[2:0]});
      e_ren = s[0];
      if (s != 7) e_step = s[2:0];
      chk("R8 step output", dut_vec(), exp_vec());
      rd1(cfg_pkg::A_REF, rb);
      chk("R8 step readback", rb, {4'b0, e_ren, e_step});
    end

    for (int c = 0; c < 4; c++) begin
      wr1(cfg_pkg::A_CHAN, {6'h3F, c[1:0]});
      e_ch = c[1:0];
      chk("R5 ch_sel output", dut_vec(), exp_vec());
      rd1(cfg_pkg::A_CHAN, rb);
      chk("R5 unused bits read zero", rb, {6'b0, c[1:0]});
    end

    xfer(1'b0, 2'd3, cfg_pkg::A_MODE, 4, 32'h02_06_FF_0D, rv, oe_ok);
    e_op = 2; e_se = 1; e_div = 1; e_dcs = 0; e_ren = 1; e_step = 5;
    chk("R4 four-byte write", dut_vec(), exp_vec());
    xfer(1'b1, 2'd3, cfg_pkg::A_MODE, 4, 32'h0, rv, oe_ok);
    chk("R4 four-byte read", rv, 32'h02_06_00_0D);
    chk("R6 oe during read data", oe_ok, 1);
    chk("R6 oe released after cs", sdio_oe, 0);

    xfer(1'b0, 2'd0, cfg_pkg::A_MODE, 2, 32'h01_03_00_00, rv, oe_ok);
    e_op = 1;
    chk("R4 extra byte ignored", dut_vec(), exp_vec());

    wr1(13'h0100, 8'hFF);
    wr1(13'h1FFF, 8'hFF);
    chk("R10 unmapped write", dut_vec(), exp_vec());
    rd1(13'h0100, rb);
    chk("R10 unmapped read", rb, 8'h00);
    chk("R6 no oe in write frames", oe_bad, 0);

    wr1(cfg_pkg::A_MODE, 8'h83);
    e_ch = 2'b11; e_op = 0; e_se = 0; e_div = 0; e_dcs = 1; e_ren = 0; e_step = 0;
    e_lvds = 1; e_fmt = 0;
    chk("R9 soft reset defaults", dut_vec(), exp_vec());
    chk("R9 stays spi mode", spi_mode, 1);
    rd1(cfg_pkg::A_MODE, rb);
    chk("R9 reset bit self-clears", rb, 8'h00);
    rd1(cfg_pkg::A_OUT, rb);
    chk("R9 strap restored", rb, 8'h08);

    finish_test();
  end
endmodule